// File: doc/BRIEF.md
# Architectural Control State Register File

This block holds the privileged control state of a processor core: the control words, the debug address, status and control registers, the extended feature register, the code segment attributes, and the stored and effective bases of eight segments. Software-visible state is reached through one indexed access channel. Several writes have side effects beyond storing the written word. A paging toggle can switch the long-mode-active flag. Some writes ask the translation cache to drop entries. Two debug indexes alias two others. Effective segment bases follow the stored bases, except when 64-bit mode ignores them.

Requests enter on `req_valid` with no back-pressure: the block accepts one access in every cycle in which `req_valid` is high, so no ready signal exists. A read answers with `rsp_valid` and `rsp_rdata` exactly one cycle later, and the response cannot be stalled. The outputs for access errors, translation-cache flushes and mode state are plain pins. Flush requests and the error flag are one-cycle pulses in the cycle after the access that causes them. The mode pins follow the stored state continuously and feed a downstream mode decoder.

Index map: 0–15 control words C0–C15; 16–23 debug registers D0–D7; 24 extended feature register; 25 code segment attributes; 32–39 stored segment bases; 40–47 effective segment bases, which are read only. Segment order within a group is ES, CS, SS, DS, FS, GS, TR, IDTR. All other indexes are unmapped.

Top module: `ctlrf_top`

## Requirements
- R1: After reset every register reads zero, except D6, which reads 0xFFFF0FF0, and D7, which reads 0x00000400. `rsp_valid`, `acc_err` and both flush pulses are low.
- R2: A C0 write whose bit 31 (paging) differs from the stored bit 31, while the extended feature register bit 8 (long enable) is 1, sets that register's bit 10 (long active) to the new bit 31. If bit 8 is 0, bit 10 keeps its value.
- R3: Every C0 write stores the written word with bit 4 forced to 1.
- R4: A C0 write that toggles bit 31 pulses `tlb_flush_all` in the following cycle. A C0 write that leaves bit 31 unchanged produces no pulse.
- R5: Every C3 write pulses `tlb_flush_nonglobal` in the following cycle.
- R6: A C4 write that toggles bit 4, 5 or 7 pulses `tlb_flush_all` in the following cycle. Toggling only other C4 bits produces no pulse.
- R7: An access to index D4 acts on D6, and an access to index D5 acts on D7.
- R8: A D6 write changes only bits 0–3, 13, 14 and 15 (mask 0x0000E00F). A D7 write changes only bits 0–7, 13 and 16–31 (mask 0xFFFF20FF). All other bits keep their values.
- R9: A code segment attribute write that changes bit 0 (long) to 1 clears the effective bases of ES, CS, SS and DS. A write that changes bit 0 to 0 reloads those effective bases from their stored bases.
- R10: A stored base write for ES, CS, SS or DS also updates that segment's effective base, unless long active and the code segment long bit are both 1. A stored base write for FS, GS, TR or IDTR always updates the effective base.
- R11: An access to C1, C5–C7, C9–C15, any unmapped index, or a write to an effective base index pulses `acc_err` in the following cycle. It changes no register and reads back zero.
- R12: A read returns `rsp_valid` high with the selected register's value one cycle after the request. `rsp_valid` is low after writes and idle cycles.
- R13: `mode_paging`, `mode_protected`, `mode_long_active`, `mode_cs_long` and `mode_cs_wide` show C0 bit 31, C0 bit 0, extended feature bit 10, and code segment attribute bits 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_idx | input | 6 | Register index |
| req_wdata | input | XLEN | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | XLEN | Read data |
| acc_err | output | 1 | Illegal access pulse |
| tlb_flush_all | output | 1 | Request to drop all translation entries |
| tlb_flush_nonglobal | output | 1 | Request to drop non-global translation entries |
| mode_paging | output | 1 | Paging enabled |
| mode_protected | output | 1 | Protection enabled |
| mode_long_active | output | 1 | Long mode active |
| mode_cs_long | output | 1 | Code segment is 64-bit |
| mode_cs_wide | output | 1 | Code segment default size is 32-bit |

## Verification
The bench targets writes that look like triggers but are not. These include a C0 write that repeats the stored paging bit, a C4 write that touches only unrelated bits, and a paging toggle while long enable is clear. A design that compares the new value with zero instead of with the stored value would flush or switch long mode spuriously here. It walks the D4/D5 aliases through the D6/D7 masks. A design that missed the alias or the mask would read back bits that should have survived or been dropped. It also writes a legacy segment base while in 64-bit mode and then leaves long mode. A design that updated the effective base too early, or failed to reload it, would return the wrong base. Reserved and read-only indexes are written and then read back to catch any leak into storage.

// File: rtl/ctlrf_pkg.sv
package ctlrf_pkg;
  localparam int IDX_W = 6;
  localparam int NSEG  = 8;
  localparam int NLEG  = 4;  // ES, CS, SS, DS: bases ignored in 64-bit mode

  localparam int B_PE   = 0;
  localparam int B_ET   = 4;
  localparam int B_PG   = 31;
  localparam int B_LME  = 8;
  localparam int B_LMA  = 10;
  localparam int B_LONG = 0;
  localparam int B_WIDE = 1;

  localparam logic [31:0] C4_FLUSH_MASK = 32'h0000_00B0;
  localparam logic [31:0] D6_WR_MASK    = 32'h0000_E00F;
  localparam logic [31:0] D7_WR_MASK    = 32'hFFFF_20FF;
  localparam logic [31:0] D6_RESET      = 32'hFFFF_0FF0;
  localparam logic [31:0] D7_RESET      = 32'h0000_0400;

  typedef enum logic [2:0] {
    K_CTL, K_DBG, K_XFEAT, K_CSATTR, K_SEGBASE, K_EFFBASE, K_BAD
  } acc_kind_e;

  typedef struct packed {
    acc_kind_e  kind;
    logic [3:0] sub;
  } acc_dec_t;
endpackage

// File: rtl/ctlrf_decode.sv
module ctlrf_decode
  import ctlrf_pkg::*;
(
  input  logic [IDX_W-1:0] idx,
  input  logic             is_write,
  output acc_dec_t         dec
);
  always_comb begin
    dec.kind = K_BAD;
    dec.sub  = idx[3:0];
    if (idx[5:4] == 2'b00) begin
      case (idx[3:0])
        4'd0, 4'd2, 4'd3, 4'd4, 4'd8: dec.kind = K_CTL;
        default:                       dec.kind = K_BAD;
      endcase
    end else if (idx[5:3] == 3'b010) begin
      dec.kind = K_DBG;
      dec.sub  = {1'b0, idx[2:0]};
      if (idx[2:0] == 3'd4) dec.sub = 4'd6;
      if (idx[2:0] == 3'd5) dec.sub = 4'd7;
    end else if (idx == 6'd24) begin
      dec.kind = K_XFEAT;
    end else if (idx == 6'd25) begin
      dec.kind = K_CSATTR;
    end else if (idx[5:3] == 3'b100) begin
      dec.kind = K_SEGBASE;
      dec.sub  = {1'b0, idx[2:0]};
    end else if (idx[5:3] == 3'b101) begin
      dec.kind = is_write ? K_BAD : K_EFFBASE;
      dec.sub  = {1'b0, idx[2:0]};
    end
  end
endmodule

// File: rtl/ctlrf_segbank.sv
module ctlrf_segbank
  import ctlrf_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [$clog2(NSEG)-1:0] wr_sel,
  input  logic [XLEN-1:0]         wr_data,
  input  logic                    in64,
  input  logic                    long_set,
  input  logic                    long_clr,
  input  logic [$clog2(NSEG)-1:0] rd_sel,
  output logic [XLEN-1:0]         base_rd,
  output logic [XLEN-1:0]         eff_rd
);
  logic [XLEN-1:0] base_q [NSEG];
  logic [XLEN-1:0] eff_q  [NSEG];

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    localparam bit LEGACY = (s < NLEG);
    logic hit;
    assign hit = wr_en && (wr_sel == s[$clog2(NSEG)-1:0]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q[s] <= '0;
        eff_q[s]  <= '0;
      end else begin
        if (hit) base_q[s] <= wr_data;
        if (LEGACY && long_set)      eff_q[s] <= '0;
        else if (LEGACY && long_clr) eff_q[s] <= base_q[s];
        else if (hit && !(LEGACY && in64)) eff_q[s] <= wr_data;
      end
    end

    if (LEGACY) begin : g_leg_chk
      assert_long_clears_eff_R9: assert property (@(posedge clk) disable iff (!rst_n)
        long_set |=> eff_q[s] == '0);
      assert_in64_keeps_eff_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && in64 && !long_set && !long_clr) |=> $stable(eff_q[s]));
    end else begin : g_sys_chk
      assert_sys_eff_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> eff_q[s] == base_q[s]);
    end
  end

  assign base_rd = base_q[rd_sel];
  assign eff_rd  = eff_q[rd_sel];
endmodule

// File: rtl/ctlrf_ctrl.sv
module ctlrf_ctrl
  import ctlrf_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  acc_dec_t        dec,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] rd_data,
  output logic            flush_all_d,
  output logic            flush_ng_d,
  output logic            long_set,
  output logic            long_clr,
  output logic            in64,
  output logic            paging,
  output logic            prot,
  output logic            long_act,
  output logic            cs_long,
  output logic            cs_wide
);
  localparam logic [XLEN-1:0] D6_MASK_X = XLEN'(D6_WR_MASK);
  localparam logic [XLEN-1:0] D7_MASK_X = XLEN'(D7_WR_MASK);
  localparam logic [XLEN-1:0] C4_MASK_X = XLEN'(C4_FLUSH_MASK);

  logic [XLEN-1:0] c0_q, c2_q, c3_q, c4_q, c8_q;
  logic [XLEN-1:0] dbp_q [4];
  logic [XLEN-1:0] d6_q, d7_q, xfeat_q, csattr_q;

  logic wr_ctl, wr_dbg, wr_c0, wr_c3, wr_c4, wr_xf, wr_cs;
  logic pg_toggle;

  assign wr_ctl = wr_en && dec.kind == K_CTL;
  assign wr_dbg = wr_en && dec.kind == K_DBG;
  assign wr_c0  = wr_ctl && dec.sub == 4'd0;
  assign wr_c3  = wr_ctl && dec.sub == 4'd3;
  assign wr_c4  = wr_ctl && dec.sub == 4'd4;
  assign wr_xf  = wr_en && dec.kind == K_XFEAT;
  assign wr_cs  = wr_en && dec.kind == K_CSATTR;

  assign pg_toggle   = wr_c0 && (wdata[B_PG] != c0_q[B_PG]);
  assign flush_all_d = pg_toggle || (wr_c4 && |((wdata ^ c4_q) & C4_MASK_X));
  assign flush_ng_d  = wr_c3;
  assign long_set    = wr_cs && !csattr_q[B_LONG] && wdata[B_LONG];
  assign long_clr    = wr_cs && csattr_q[B_LONG] && !wdata[B_LONG];
  assign in64        = xfeat_q[B_LMA] && csattr_q[B_LONG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c0_q <= '0; c2_q <= '0; c3_q <= '0; c4_q <= '0; c8_q <= '0;
      for (int i = 0; i < 4; i++) dbp_q[i] <= '0;
      d6_q     <= XLEN'(D6_RESET);
      d7_q     <= XLEN'(D7_RESET);
      xfeat_q  <= '0;
      csattr_q <= '0;
    end else begin
      if (wr_ctl) begin
        case (dec.sub)
          4'd0:    c0_q <= wdata | (XLEN'(1) << B_ET);
          4'd2:    c2_q <= wdata;
          4'd3:    c3_q <= wdata;
          4'd4:    c4_q <= wdata;
          default: c8_q <= wdata;
        endcase
      end
      if (wr_dbg) begin
        case (dec.sub)
          4'd6:    d6_q <= (d6_q & ~D6_MASK_X) | (wdata & D6_MASK_X);
          4'd7:    d7_q <= (d7_q & ~D7_MASK_X) | (wdata & D7_MASK_X);
          default: dbp_q[dec.sub[1:0]] <= wdata;
        endcase
      end
      if (wr_xf) xfeat_q <= wdata;
      else if (pg_toggle && xfeat_q[B_LME]) xfeat_q[B_LMA] <= wdata[B_PG];
      if (wr_cs) csattr_q <= wdata;
    end
  end

  always_comb begin
    rd_data = '0;
    case (dec.kind)
      K_CTL: begin
        case (dec.sub)
          4'd0:    rd_data = c0_q;
          4'd2:    rd_data = c2_q;
          4'd3:    rd_data = c3_q;
          4'd4:    rd_data = c4_q;
          default: rd_data = c8_q;
        endcase
      end
      K_DBG: begin
        case (dec.sub)
          4'd6:    rd_data = d6_q;
          4'd7:    rd_data = d7_q;
          default: rd_data = dbp_q[dec.sub[1:0]];
        endcase
      end
      K_XFEAT:  rd_data = xfeat_q;
      K_CSATTR: rd_data = csattr_q;
      default:  rd_data = '0;
    endcase
  end

  assign paging   = c0_q[B_PG];
  assign prot     = c0_q[B_PE];
  assign long_act = xfeat_q[B_LMA];
  assign cs_long  = csattr_q[B_LONG];
  assign cs_wide  = csattr_q[B_WIDE];

  assert_et_forced_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_c0 |=> c0_q[B_ET]);
  assert_lma_follows_pg_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_toggle && xfeat_q[B_LME]) |=> xfeat_q[B_LMA] == $past(wdata[B_PG]));
  assert_d6_fixed_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dbg && dec.sub == 4'd6) |=> (d6_q & ~D6_MASK_X) == $past(d6_q & ~D6_MASK_X));
  assert_d7_fixed_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dbg && dec.sub == 4'd7) |=> (d7_q & ~D7_MASK_X) == $past(d7_q & ~D7_MASK_X));
endmodule

// File: rtl/ctlrf_top.sv
module ctlrf_top
  import ctlrf_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [IDX_W-1:0] req_idx,
  input  logic [XLEN-1:0]  req_wdata,
  output logic             rsp_valid,
  output logic [XLEN-1:0]  rsp_rdata,
  output logic             acc_err,
  output logic             tlb_flush_all,
  output logic             tlb_flush_nonglobal,
  output logic             mode_paging,
  output logic             mode_protected,
  output logic             mode_long_active,
  output logic             mode_cs_long,
  output logic             mode_cs_wide
);
  localparam int SEL_W = $clog2(NSEG);

  acc_dec_t        dec;
  logic            legal, wr_en, rd_en;
  logic [XLEN-1:0] ctrl_rd, base_rd, eff_rd, rd_mux;
  logic            fa_d, fng_d, long_set, long_clr, in64;

  ctlrf_decode u_dec (
    .idx      (req_idx),
    .is_write (req_write),
    .dec      (dec)
  );

  assign legal = dec.kind != K_BAD;
  assign wr_en = req_valid && req_write && legal;
  assign rd_en = req_valid && !req_write;

  ctlrf_ctrl #(.XLEN(XLEN)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .dec         (dec),
    .wdata       (req_wdata),
    .rd_data     (ctrl_rd),
    .flush_all_d (fa_d),
    .flush_ng_d  (fng_d),
    .long_set    (long_set),
    .long_clr    (long_clr),
    .in64        (in64),
    .paging      (mode_paging),
    .prot        (mode_protected),
    .long_act    (mode_long_active),
    .cs_long     (mode_cs_long),
    .cs_wide     (mode_cs_wide)
  );

  ctlrf_segbank #(.XLEN(XLEN)) u_seg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en && dec.kind == K_SEGBASE),
    .wr_sel   (dec.sub[SEL_W-1:0]),
    .wr_data  (req_wdata),
    .in64     (in64),
    .long_set (long_set),
    .long_clr (long_clr),
    .rd_sel   (dec.sub[SEL_W-1:0]),
    .base_rd  (base_rd),
    .eff_rd   (eff_rd)
  );

  always_comb begin
    case (dec.kind)
      K_SEGBASE: rd_mux = base_rd;
      K_EFFBASE: rd_mux = eff_rd;
      default:   rd_mux = ctrl_rd;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid           <= 1'b0;
      rsp_rdata           <= '0;
      acc_err             <= 1'b0;
      tlb_flush_all       <= 1'b0;
      tlb_flush_nonglobal <= 1'b0;
    end else begin
      rsp_valid           <= rd_en;
      rsp_rdata           <= (rd_en && legal) ? rd_mux : '0;
      acc_err             <= req_valid && !legal;
      tlb_flush_all       <= fa_d;
      tlb_flush_nonglobal <= fng_d;
    end
  end

  assert_bad_access_flags_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !legal) |=> acc_err && rsp_rdata == '0);
  assert_read_latency_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rsp_valid);
  assert_no_rsp_on_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rsp_valid);
  assert_flush_ng_on_c3_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && dec.kind == K_CTL && dec.sub == 4'd3) |=> tlb_flush_nonglobal);
endmodule

// File: tb/ctlrf_top_tb.sv
module ctlrf_top_tb;
  localparam int XLEN = 64;
  localparam int NV   = 36;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            req_valid, req_write;
  logic [5:0]      req_idx;
  logic [XLEN-1:0] req_wdata;
  logic            rsp_valid, acc_err, tlb_flush_all, tlb_flush_nonglobal;
  logic [XLEN-1:0] rsp_rdata;
  logic            mode_paging, mode_protected, mode_long_active, mode_cs_long, mode_cs_wide;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ctlrf_top #(.XLEN(XLEN)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_idx(req_idx), .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .acc_err(acc_err), .tlb_flush_all(tlb_flush_all), .tlb_flush_nonglobal(tlb_flush_nonglobal),
    .mode_paging(mode_paging), .mode_protected(mode_protected), .mode_long_active(mode_long_active),
    .mode_cs_long(mode_cs_long), .mode_cs_wide(mode_cs_wide)
  );

  // {req number, write, index, data (write data or expected read), flags {err, flush_all, flush_ng}}
  localparam logic [45:0] VEC [NV] = '{
    {4'd2,  1'b1, 6'd24, 32'h0000_0100, 3'b000}, // R2 long enable
    {4'd4,  1'b1, 6'd0,  32'h8000_0001, 3'b010}, // R4 paging on
    {4'd2,  1'b0, 6'd24, 32'h0000_0500, 3'b000}, // R2 long active set
    {4'd3,  1'b0, 6'd0,  32'h8000_0011, 3'b000}, // R3 bit 4 forced
    {4'd4,  1'b1, 6'd0,  32'h8000_0001, 3'b000}, // R4 no toggle
    {4'd5,  1'b1, 6'd3,  32'h0000_1000, 3'b001}, // R5
    {4'd12, 1'b0, 6'd3,  32'h0000_1000, 3'b000}, // R12 readback
    {4'd6,  1'b1, 6'd4,  32'h0000_0010, 3'b010}, // R6 bit 4 toggle
    {4'd6,  1'b1, 6'd4,  32'h0000_0011, 3'b000}, // R6 unrelated bit
    {4'd6,  1'b1, 6'd4,  32'h0000_00B1, 3'b010}, // R6 bits 5 and 7
    {4'd7,  1'b1, 6'd20, 32'hFFFF_FFFF, 3'b000}, // R7 D4 -> D6
    {4'd8,  1'b0, 6'd22, 32'hFFFF_EFFF, 3'b000}, // R8 D6 mask
    {4'd8,  1'b1, 6'd22, 32'h0000_0000, 3'b000}, // R8
    {4'd7,  1'b0, 6'd20, 32'hFFFF_0FF0, 3'b000}, // R7 read via D4
    {4'd7,  1'b1, 6'd21, 32'hFFFF_FFFF, 3'b000}, // R7 D5 -> D7
    {4'd8,  1'b0, 6'd23, 32'hFFFF_24FF, 3'b000}, // R8 D7 mask
    {4'd12, 1'b1, 6'd17, 32'h0000_ABCD, 3'b000}, // R12 D1 plain
    {4'd12, 1'b0, 6'd17, 32'h0000_ABCD, 3'b000}, // R12
    {4'd10, 1'b1, 6'd32, 32'h0000_1111, 3'b000}, // R10 ES base, not 64-bit
    {4'd10, 1'b0, 6'd40, 32'h0000_1111, 3'b000}, // R10
    {4'd9,  1'b1, 6'd25, 32'h0000_0001, 3'b000}, // R9 long bit on
    {4'd9,  1'b0, 6'd40, 32'h0000_0000, 3'b000}, // R9 cleared
    {4'd10, 1'b1, 6'd32, 32'h0000_2222, 3'b000}, // R10 ES base in 64-bit
    {4'd10, 1'b0, 6'd40, 32'h0000_0000, 3'b000}, // R10 eff untouched
    {4'd10, 1'b0, 6'd32, 32'h0000_2222, 3'b000}, // R10 stored base
    {4'd10, 1'b1, 6'd36, 32'h0000_3333, 3'b000}, // R10 FS in 64-bit
    {4'd10, 1'b0, 6'd44, 32'h0000_3333, 3'b000}, // R10
    {4'd9,  1'b1, 6'd25, 32'h0000_0000, 3'b000}, // R9 long bit off
    {4'd9,  1'b0, 6'd40, 32'h0000_2222, 3'b000}, // R9 reload
    {4'd11, 1'b1, 6'd5,  32'h0000_DEAD, 3'b100}, // R11 C5
    {4'd11, 1'b0, 6'd5,  32'h0000_0000, 3'b100}, // R11
    {4'd11, 1'b1, 6'd1,  32'h0000_BEEF, 3'b100}, // R11 C1
    {4'd2,  1'b1, 6'd0,  32'h0000_0001, 3'b010}, // R2 paging off
    {4'd2,  1'b0, 6'd24, 32'h0000_0100, 3'b000}, // R2 long active cleared
    {4'd2,  1'b1, 6'd24, 32'h0000_0000, 3'b000}, // R2 long enable off
    {4'd2,  1'b1, 6'd0,  32'h8000_0001, 3'b010}  // R2 toggle without enable
  };

  task automatic check(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic op(input logic w, input logic [5:0] idx, input logic [XLEN-1:0] d);
    req_valid = 1'b1; req_write = w; req_idx = idx; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_idx = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 flags", {60'd0, rsp_valid, acc_err, tlb_flush_all, tlb_flush_nonglobal}, '0);
    check("R1 mode", {59'd0, mode_paging, mode_protected, mode_long_active, mode_cs_long, mode_cs_wide}, '0);
    op(1'b0, 6'd0, '0);  check("R1 C0", rsp_rdata, '0);
    op(1'b0, 6'd22, '0); check("R1 D6", rsp_rdata, 64'hFFFF_0FF0);
    op(1'b0, 6'd23, '0); check("R1 D7", rsp_rdata, 64'h0000_0400);
    op(1'b0, 6'd24, '0); check("R1 xfeat", rsp_rdata, '0);
    op(1'b0, 6'd40, '0); check("R1 eff ES", rsp_rdata, '0);

    for (int i = 0; i < NV; i++) begin
      logic [45:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d vec%0d", v[45:42], i);
      op(v[41], v[40:35], {32'd0, v[34:3]});
      check({tag, " flags"}, {61'd0, acc_err, tlb_flush_all, tlb_flush_nonglobal}, {61'd0, v[2:0]});
      check({tag, " rsp_valid"}, {63'd0, rsp_valid}, {63'd0, !v[41]});
      if (!v[41]) check({tag, " data"}, rsp_rdata, {32'd0, v[34:3]});
    end

    // R13 mode outputs: C0 = 0x80000011, xfeat = 0, attrs = 0
    check("R13 paging/prot/long", {61'd0, mode_paging, mode_protected, mode_long_active}, 64'b110);
    op(1'b1, 6'd25, 64'h3);
    check("R13 cs bits", {62'd0, mode_cs_long, mode_cs_wide}, 64'b11);
    // R11 write to read-only effective base index changes nothing
    op(1'b1, 6'd40, 64'h9999);
    check("R11 eff write err", {63'd0, acc_err}, 64'd1);
    op(1'b0, 6'd40, '0);
    check("R11 eff unchanged", rsp_rdata, 64'h0);  // cs long set above cleared legacy eff
    op(1'b0, 6'd50, '0);
    check("R11 unmapped read", {acc_err, rsp_rdata[62:0]}, {1'b1, 63'd0});
    // R12 idle cycle
    @(negedge clk);
    check("R12 idle", {62'd0, rsp_valid, acc_err}, '0);
    // R1 mid-run reset
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    op(1'b0, 6'd23, '0); check("R1 D7 after reset", rsp_rdata, 64'h0000_0400);
    op(1'b0, 6'd32, '0); check("R1 ES base after reset", rsp_rdata, '0);

    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule